// File: doc/BRIEF.md
# Temporal Window Property Checker

A clock-synchronous monitor that watches one Boolean signal over a bounded stretch of cycles and reports whether a chosen property held there. A window is opened either by a trigger, in which case it spans a programmed range of cycles counted from the trigger, or by a start event, in which case it lasts until an end event arrives. Four check kinds are available: the signal is seen true at least once, the signal stays true throughout, the signal keeps the value it had at window entry, or the signal moves away from its entry value.

Any logic in the design can cut a window short. An accept strobe ends it with a pass. A reject strobe drops the attempt with no verdict. Every pass also raises a completion pulse, which can feed a coverage counter or act as the trigger of another checker. The block only observes: all of its ports that face the design are inputs, apart from its own verdict outputs.

Top module: `temporal_window_checker`

## Requirements
- R1: While idle, a high `trig_i` at a rising edge opens a timed window and `busy_o` goes high after that edge. Rising edge k after the opening edge samples cycle k. Cycles `min_cyc_i`..`max_cyc_i` (inclusive) are inside the window. Mode and bounds are latched at opening, so later changes have no effect on the open window.
- R2: While idle, with `trig_i` low, a high `start_evt_i` opens an event window. `trig_i` wins if both are high. Every later edge is an in-window sample, and the sample taken with `end_evt_i` high is the last one.
- R3: Mode 0 (occurs) passes at the first in-window sample with `expr_i` high. It fails at the last sample if no such sample occurred.
- R4: Mode 1 (holds) fails at the first in-window sample with `expr_i` low. Otherwise it passes at the last sample.
- R5: Mode 2 (stable) takes the first in-window sample as the reference. It fails at any later in-window sample that differs from the reference, and otherwise passes at the last sample.
- R6: Mode 3 (change) takes the first in-window sample as the reference. It passes at the first later in-window sample that differs from the reference, and otherwise fails at the last sample.
- R7: While busy, `reject_i` ends the window with neither pass nor fail. `accept_i` ends it with a pass. Reject beats accept, and both beat the property result. Both strobes are ignored while idle.
- R8: `trig_i` and `start_evt_i` are ignored while a window is open, and the cycle count is not restarted.
- R9: A verdict for the sample at edge E appears on `pass_o` or `fail_o` after E, for exactly one cycle, and `busy_o` is low from that point. `done_o` pulses together with every pass. Pass and fail never occur together.
- R10: A `min_cyc_i` of 0 is treated as 1. A `max_cyc_i` below the effective minimum is treated as equal to it.
- R11: After reset, `pass_o`, `fail_o`, `done_o` and `busy_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Design clock; all sampling on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Opens a timed window when idle |
| start_evt_i | input | 1 | Opens an event window when idle |
| end_evt_i | input | 1 | Marks the last sample of an event window |
| expr_i | input | 1 | Monitored Boolean signal |
| mode_i | input | 2 | Check kind: 0 occurs, 1 holds, 2 stable, 3 change |
| min_cyc_i | input | CNT_W | First in-window cycle of a timed window |
| max_cyc_i | input | CNT_W | Last in-window cycle of a timed window |
| accept_i | input | 1 | Ends the open window with a pass |
| reject_i | input | 1 | Discards the open window silently |
| pass_o | output | 1 | One-cycle pass verdict |
| fail_o | output | 1 | One-cycle fail verdict |
| busy_o | output | 1 | A window is open |
| done_o | output | 1 | One-cycle completion pulse on every pass |

## Verification
The embedded properties assume that every input changes only between rising edges of `clk_i`, and that a timed window's count never wraps. The clamping of the bounds ensures the second, because the counter stops at the effective maximum. The bench drives every input on the falling edge and reads results on the next falling edge, so each sample sits one half period from any input change. Strobes and events are held for a single cycle. The window bounds stay well below the counter range. Mode and bound inputs are deliberately scrambled while a window is open, to show that the latched values govern the window.

// File: rtl/twc_pkg.sv
package twc_pkg;
  typedef enum logic [1:0] {
    CHK_OCCUR  = 2'd0,
    CHK_HOLD   = 2'd1,
    CHK_STABLE = 2'd2,
    CHK_CHANGE = 2'd3
  } chk_mode_e;

  typedef enum logic [1:0] {
    WIN_IDLE  = 2'd0,
    WIN_TIMED = 2'd1,
    WIN_EVENT = 2'd2
  } win_state_e;
endpackage

// File: rtl/twc_window_ctrl.sv
module twc_window_ctrl
  import twc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             start_evt_i,
  input  logic             end_evt_i,
  input  logic [CNT_W-1:0] min_cyc_i,
  input  logic [CNT_W-1:0] max_cyc_i,
  input  logic             close_i,
  output logic             open_o,
  output logic             active_o,
  output logic             in_win_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  win_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, min_q, max_q;
  logic [CNT_W-1:0] min_eff, max_eff;
  logic             idle, open_timed, open_event;

  assign idle       = (state_q == WIN_IDLE);
  assign open_timed = idle && trig_i;
  assign open_event = idle && !trig_i && start_evt_i;
  assign open_o     = open_timed || open_event;
  assign active_o   = !idle;

  // bound clamping: min >= 1, max >= min
  assign min_eff = (min_cyc_i == '0) ? ONE : min_cyc_i;
  assign max_eff = (max_cyc_i < min_eff) ? min_eff : max_cyc_i;

  assign in_win_o = (state_q == WIN_EVENT) ||
                    ((state_q == WIN_TIMED) && (cnt_q >= min_q) && (cnt_q <= max_q));
  assign last_o   = ((state_q == WIN_TIMED) && (cnt_q == max_q)) ||
                    ((state_q == WIN_EVENT) && end_evt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WIN_IDLE;
      cnt_q   <= '0;
      min_q   <= ONE;
      max_q   <= ONE;
    end else if (open_timed) begin
      state_q <= WIN_TIMED;
      cnt_q   <= ONE;
      min_q   <= min_eff;
      max_q   <= max_eff;
    end else if (open_event) begin
      state_q <= WIN_EVENT;
      cnt_q   <= '0;
    end else if (active_o && close_i) begin
      state_q <= WIN_IDLE;
    end else if (state_q == WIN_TIMED) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  // R1: the closing logic must retire a timed window at its maximum
  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WIN_TIMED) |-> (cnt_q <= max_q && cnt_q >= ONE));

  // R8: an open timed window is never restarted by a new trigger
  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WIN_TIMED && $past(state_q) == WIN_TIMED) |-> (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/twc_mode_eval.sv
module twc_mode_eval
  import twc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       open_i,
  input  logic [1:0] mode_i,
  input  logic       sample_i,
  input  logic       last_i,
  input  logic       expr_i,
  output logic       pass_o,
  output logic       fail_o
);
  chk_mode_e mode_q;
  logic      ref_q, have_ref_q, differ, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= CHK_OCCUR;
      ref_q      <= 1'b0;
      have_ref_q <= 1'b0;
    end else if (open_i) begin
      mode_q     <= chk_mode_e'(mode_i);
      have_ref_q <= 1'b0;
    end else if (sample_i && !have_ref_q) begin
      ref_q      <= expr_i;
      have_ref_q <= 1'b1;
    end
  end

  assign differ = have_ref_q && (expr_i != ref_q);

  always_comb begin
    pass_o = 1'b0;
    fail_o = 1'b0;
    hit    = 1'b0;
    unique case (mode_q)
      CHK_OCCUR: begin
        hit    = sample_i && expr_i;
        pass_o = hit;
        fail_o = last_i && !hit;
      end
      CHK_HOLD: begin
        fail_o = sample_i && !expr_i;
        pass_o = last_i && !fail_o;
      end
      CHK_STABLE: begin
        fail_o = sample_i && differ;
        pass_o = last_i && !fail_o;
      end
      CHK_CHANGE: begin
        pass_o = sample_i && differ;
        fail_o = last_i && !pass_o;
      end
      default: ;
    endcase
  end

  // R5/R6: the reference is frozen once captured within a window
  a_r5_ref_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (have_ref_q && $past(have_ref_q) && !$past(open_i)) |-> $stable(ref_q));
endmodule

// File: rtl/temporal_window_checker.sv
module temporal_window_checker
  import twc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             start_evt_i,
  input  logic             end_evt_i,
  input  logic             expr_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] min_cyc_i,
  input  logic [CNT_W-1:0] max_cyc_i,
  input  logic             accept_i,
  input  logic             reject_i,
  output logic             pass_o,
  output logic             fail_o,
  output logic             busy_o,
  output logic             done_o
);
  logic open, active, in_win, last, close;
  logic v_pass, v_fail, pass_d, fail_d;
  logic pass_q, fail_q, done_q;

  twc_window_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig_i),
    .start_evt_i (start_evt_i),
    .end_evt_i   (end_evt_i),
    .min_cyc_i   (min_cyc_i),
    .max_cyc_i   (max_cyc_i),
    .close_i     (close),
    .open_o      (open),
    .active_o    (active),
    .in_win_o    (in_win),
    .last_o      (last)
  );

  twc_mode_eval u_eval (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .open_i   (open),
    .mode_i   (mode_i),
    .sample_i (active && in_win),
    .last_i   (last),
    .expr_i   (expr_i),
    .pass_o   (v_pass),
    .fail_o   (v_fail)
  );

  // reject > accept > property result
  assign pass_d = active && !reject_i && (accept_i || v_pass);
  assign fail_d = active && !reject_i && !accept_i && v_fail;
  assign close  = active && (reject_i || accept_i || v_pass || v_fail);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pass_q <= pass_d;
      fail_q <= fail_d;
      done_q <= pass_d;
    end
  end

  assign pass_o = pass_q;
  assign fail_o = fail_q;
  assign done_o = done_q;
  assign busy_o = active;

  a_r9_single_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |=> !pass_o);
  a_r9_single_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o);
  a_r9_one_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));
  a_r9_idle_after_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || fail_o) |-> !busy_o);
  a_r9_verdict_needs_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || fail_o) |-> $past(busy_o));
  a_r7_reject_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reject_i) |=> (!pass_o && !fail_o && !busy_o));
  a_r7_accept_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && accept_i && !reject_i) |=> (pass_o && done_o));
endmodule

// File: tb/tb_temporal_window_checker.sv
`timescale 1ns/1ps
module tb_temporal_window_checker;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 0, start_evt = 0, end_evt = 0, expr = 0, accept = 0, reject = 0;
  logic [1:0] mode = 0;
  logic [CW-1:0] min_cyc = 1, max_cyc = 1;
  logic pass_w, fail_w, busy_w, done_w;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  temporal_window_checker #(.CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .start_evt_i(start_evt),
    .end_evt_i(end_evt), .expr_i(expr), .mode_i(mode), .min_cyc_i(min_cyc),
    .max_cyc_i(max_cyc), .accept_i(accept), .reject_i(reject),
    .pass_o(pass_w), .fail_o(fail_w), .busy_o(busy_w), .done_o(done_w)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // kind: 0 pass, 1 fail, 2 none (discarded)
  task automatic run_win(input bit evt, input bit both, input int md,
                         input int mn, input int mx, input logic [31:0] pat,
                         input int end_k, input int acc_k, input int rej_k,
                         input int retrig_k, input int exp_kind, input int exp_k,
                         input string req);
    int got_k = 0;
    int got_kind = 3;
    mode = md[1:0]; min_cyc = mn[CW-1:0]; max_cyc = mx[CW-1:0];
    trig = !evt || both; start_evt = evt || both;
    step();
    trig = 0; start_evt = 0;
    chk(busy_w == 1'b1, {req, " busy after open"}, busy_w, 1);
    mode = ~md[1:0]; min_cyc = 8'd9; max_cyc = 8'd2;  // latched values must rule
    for (int k = 1; k <= 24; k++) begin
      expr = pat[k];
      end_evt = evt && (k == end_k);
      accept = (k == acc_k);
      reject = (k == rej_k);
      trig = (k == retrig_k);
      start_evt = (k == retrig_k);
      step();
      if (pass_w || fail_w || !busy_w) begin
        got_k = k;
        got_kind = pass_w ? 0 : (fail_w ? 1 : 2);
        break;
      end
    end
    end_evt = 0; accept = 0; reject = 0; trig = 0; start_evt = 0; expr = 0;
    chk(got_kind == exp_kind, {req, " verdict"}, got_kind, exp_kind);
    chk(got_k == exp_k, {req, " verdict cycle"}, got_k, exp_k);
    chk(done_w == pass_w, {req, " R9 done with pass"}, done_w, pass_w);
    chk(busy_w == 1'b0, {req, " R9 idle at verdict"}, busy_w, 0);
    step();
    chk({pass_w, fail_w, done_w} == 3'b000, {req, " R9 single pulse"},
        {pass_w, fail_w, done_w}, 0);
  endtask

  task automatic t_reset();
    chk({pass_w, fail_w, done_w, busy_w} == 4'b0000, "R11 reset outputs",
        {pass_w, fail_w, done_w, busy_w}, 0);
  endtask

  task automatic t_occurs();
    run_win(0, 0, 0, 2, 4, 32'h0008, 0, 0, 0, 0, 0, 3, "R3 R1 occurs hit");
    run_win(0, 0, 0, 2, 4, 32'h0022, 0, 0, 0, 0, 1, 4, "R3 R1 occurs outside only");
  endtask

  task automatic t_holds();
    run_win(0, 0, 1, 2, 4, 32'h001C, 0, 0, 0, 0, 0, 4, "R4 holds pass");
    run_win(0, 0, 1, 2, 4, 32'h0014, 0, 0, 0, 0, 1, 3, "R4 holds drop");
  endtask

  task automatic t_stable();
    run_win(0, 0, 2, 1, 3, 32'h000E, 0, 0, 0, 0, 0, 3, "R5 stable pass");
    run_win(0, 0, 2, 1, 3, 32'h0002, 0, 0, 0, 0, 1, 2, "R5 stable moved");
  endtask

  task automatic t_change();
    run_win(0, 0, 3, 2, 5, 32'h0012, 0, 0, 0, 0, 0, 4, "R6 change seen");
    run_win(0, 0, 3, 2, 5, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, 5, "R6 change absent");
  endtask

  task automatic t_event();
    run_win(1, 0, 0, 1, 1, 32'h0000, 3, 0, 0, 0, 1, 3, "R2 event occurs miss");
    run_win(1, 0, 1, 1, 1, 32'hFFFF_FFFF, 2, 0, 0, 0, 0, 2, "R2 event holds");
    run_win(1, 0, 2, 1, 1, 32'h0006, 4, 0, 0, 0, 1, 3, "R2 R5 event stable");
    run_win(1, 0, 3, 1, 1, 32'h0000, 1, 0, 0, 0, 1, 1, "R2 R6 event one sample");
    run_win(1, 1, 0, 1, 2, 32'h0000, 0, 0, 0, 0, 1, 2, "R2 trigger precedence");
  endtask

  task automatic t_strobes();
    run_win(0, 0, 1, 3, 6, 32'h0000, 0, 2, 0, 0, 0, 2, "R7 accept early");
    run_win(0, 0, 0, 3, 6, 32'hFFFF_FFFF, 0, 0, 2, 0, 2, 2, "R7 reject discards");
    run_win(0, 0, 0, 3, 6, 32'h0000, 0, 2, 2, 0, 2, 2, "R7 reject over accept");
    accept = 1; reject = 0;
    step();
    accept = 0;
    chk({pass_w, done_w, busy_w} == 3'b000, "R7 accept ignored idle",
        {pass_w, done_w, busy_w}, 0);
  endtask

  task automatic t_retrigger();
    run_win(0, 0, 0, 3, 5, 32'h0008, 0, 0, 0, 1, 0, 3, "R8 retrigger ignored");
  endtask

  task automatic t_clamp();
    run_win(0, 0, 0, 0, 0, 32'h0002, 0, 0, 0, 0, 0, 1, "R10 zero bounds");
    run_win(0, 0, 0, 3, 1, 32'h0008, 0, 0, 0, 0, 0, 3, "R10 max below min hit");
    run_win(0, 0, 0, 3, 1, 32'h0014, 0, 0, 0, 0, 1, 3, "R10 max below min miss");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_occurs();
    t_holds();
    t_stable();
    t_change();
    t_event();
    t_strobes();
    t_retrigger();
    t_clamp();
    finish_run();
  end
endmodule